// File: doc/BRIEF.md
# Indexed Command/Data Register Host Port

This block is the host-facing register port of a display controller. A single 16-bit bus carries both register indices and register values, and a data/command select line tells them apart. A write with the select low loads an 8-bit register index. A write with the select high stores into the indexed register through that register's own writable-bit mask. A read returns the indexed register on `bus_rdata` one cycle after the access.

After a data write the index steps forward by two, so that a run of consecutive registers can be programmed without reloading the index. Three streaming ports keep the index fixed so that repeated writes feed the same port: the pixel memory port, the gamma table data port and the filter coefficient data port. The two table ports keep their own post-incremented entry pointers. Ten-bit window coordinates are split over a low and a high register. The interrupt status register is cleared by writing zeros into it.

The first `SKIP_N` bus accesses after reset are swallowed. The sequencer has two states. `ST_SWALLOW` is the reset state whenever `SKIP_N > 0`, and there every access only decrements the swallow counter. The transition to `ST_ACTIVE` fires on the access that brings the count from 1 to 0. `ST_ACTIVE` accepts every access and has no exit other than reset.

Top module: `crp_host_port`

## Requirements
- R1: A live access with `bus_we`=1 and `bus_dc`=0 loads `bus_wdata[7:0]` into the register index.
- R2: A live data write (`bus_we`=1, `bus_dc`=1) advances the index by 2, except at 0x90, 0x5A and 0xB8, where the index stays unchanged.
- R3: A read sets `bus_rdata` to the indexed register's value on the clock edge of the access. The index advances by 1 only when `bus_dc`=1.
- R4: The first `SKIP_N` accesses after reset change no state and produce no output pulse. A swallowed read sets `bus_rdata` to 0.
- R5: Index 0x00 reads 0x00A5 and index 0x02 reads 0x0083. Writes to either index have no effect.
- R6: Index 0x04 (divider) stores `bus_wdata[5:0]`+1 and reads back (stored−1) with bit 7 set. It reads 0x0088 after reset.
- R7: Coordinate pairs are X at 0x6C (low) and 0x6E (high), and Y at 0x70 (low) and 0x72 (high). A low write sets bits 7:0 from `bus_wdata[7:0]`. A high write sets bits 9:8 from `bus_wdata[1:0]`. Each write keeps the other part. A high read returns bits 9:8 in bits 1:0.
- R8: Index 0xB6 holds the 8-bit gamma pointer. Any read, and any data write, at 0xB8 accesses the entry at that pointer and then increments it, wrapping from 255 to 0.
- R9: Index 0x58 loads the filter pointer with `bus_wdata[4:0]`. An access at 0x5A post-increments the pointer while it is below 32. At 32 the pointer stays, reads return 0 and writes are dropped. The pointer reads back as 0x20.
- R10: A data write to index 0xF6 ANDs `bus_wdata[7:0]` into the interrupt status. Every cycle, `irq_set` bits are ORed in, and a set wins over a clear in the same cycle.
- R11: Index 0x68 stores `bus_wdata[7:0]` & 0xB7. `disp_enable` is stored bit 0 and `disp_blank` is stored bit 1. `invalidate` pulses for one cycle after a write that changes either of those bits.
- R12: A data write to 0x90 pulses `mem_push` for one cycle after the access, with `mem_data` equal to the written word. Reads of 0x90 return 0.
- R13: An unknown index reads 0 and ignores writes. Any live access to it with `bus_dc`=1 sets `idx_err`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_acc | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_dc | input | 1 | Data/command select (1 = data) |
| bus_wdata | input | 16 | Write value or register index |
| bus_rdata | output | 16 | Read result, registered |
| irq_set | input | 8 | Interrupt status set bits |
| disp_enable | output | 1 | Display enable (mode bit 0) |
| disp_blank | output | 1 | Display blank (mode bit 1) |
| invalidate | output | 1 | One-cycle pulse on an enable/blank change |
| mem_push | output | 1 | One-cycle pulse per memory-port word |
| mem_data | output | 16 | Word pushed to the memory port |
| idx_err | output | 1 | Sticky unknown-index flag |

## Verification
The assertions check, on every cycle, that a command write loads the index and that streaming-port writes hold it. They also check that nothing moves while accesses are being swallowed, that table pointers step or stop as their port rules require, that an interrupt-status write leaves no cleared bit set, that `invalidate` and `mem_push` follow their causing writes, and that `idx_err` never drops. Only the bench scenarios can show the values that come back: the constant and divider encodings, split-coordinate preservation, gamma pointer wrap, the filter pointer saturating at 32, set-over-clear priority, and the exact count of swallowed accesses.

// File: rtl/crp_pkg.sv
package crp_pkg;

    typedef enum logic {ST_SWALLOW, ST_ACTIVE} seq_state_t;

    localparam logic [7:0] IX_REV   = 8'h00;
    localparam logic [7:0] IX_CFG   = 8'h02;
    localparam logic [7:0] IX_DIV   = 8'h04;
    localparam logic [7:0] IX_FIDX  = 8'h58;
    localparam logic [7:0] IX_FDAT  = 8'h5A;
    localparam logic [7:0] IX_MODE  = 8'h68;
    localparam logic [7:0] IX_CRD   = 8'h6C;
    localparam logic [7:0] IX_MEM   = 8'h90;
    localparam logic [7:0] IX_GIDX  = 8'hB6;
    localparam logic [7:0] IX_GDAT  = 8'hB8;
    localparam logic [7:0] IX_IRQ   = 8'hF6;

    localparam logic [15:0] REV_VAL = 16'h00A5;
    localparam logic [15:0] CFG_VAL = 16'h0083;
    localparam logic [7:0]  MODE_WMASK = 8'hB7;

    function automatic logic is_stream(input logic [7:0] ix);
        return (ix == IX_MEM) || (ix == IX_FDAT) || (ix == IX_GDAT);
    endfunction

    function automatic logic [7:0] crd_lo(input int n);
        return IX_CRD + 8'(4 * n);
    endfunction

    function automatic logic [7:0] crd_hi(input int n);
        return IX_CRD + 8'(4 * n + 2);
    endfunction

    function automatic logic is_known(input logic [7:0] ix, input int ncrd);
        logic hit;
        hit = (ix == IX_REV) || (ix == IX_CFG) || (ix == IX_DIV) ||
              (ix == IX_FIDX) || (ix == IX_FDAT) || (ix == IX_MODE) ||
              (ix == IX_MEM) || (ix == IX_GIDX) || (ix == IX_GDAT) ||
              (ix == IX_IRQ);
        for (int k = 0; k < ncrd; k++)
            if (ix == crd_lo(k) || ix == crd_hi(k)) hit = 1'b1;
        return hit;
    endfunction

endpackage

// File: rtl/crp_seq.sv
module crp_seq
    import crp_pkg::*;
#(
    parameter int SKIP_N = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc,
    input  logic       we,
    input  logic       dc,
    input  logic [7:0] wcmd,
    output logic [7:0] cur_idx,
    output logic       live
);
    localparam int CW = (SKIP_N > 0) ? $clog2(SKIP_N + 1) : 1;
    localparam seq_state_t RST_ST = (SKIP_N > 0) ? ST_SWALLOW : ST_ACTIVE;

    seq_state_t st, st_nx;
    logic [CW-1:0] cnt;
    logic [7:0]    idx;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_SWALLOW: if (acc && cnt <= CW'(1)) st_nx = ST_ACTIVE;
            ST_ACTIVE:  st_nx = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= RST_ST;
            cnt <= CW'(SKIP_N);
        end else begin
            st <= st_nx;
            if (st == ST_SWALLOW && acc) cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        live    = (st == ST_ACTIVE) && acc;
        cur_idx = idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= 8'h00;
        end else if (live) begin
            if (we && !dc)                        idx <= wcmd;
            else if (we && dc && !is_stream(idx)) idx <= idx + 8'd2;
            else if (!we && dc)                   idx <= idx + 8'd1;
        end
    end

    AST_CMD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (live && we && !dc) |=> (cur_idx == $past(wcmd)))
        else $error("command load"); // R1
    AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (live && we && dc && is_stream(cur_idx)) |=> $stable(cur_idx))
        else $error("stream hold"); // R2
    AST_SWALLOW_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SWALLOW) |=> $stable(cur_idx))
        else $error("swallow nop"); // R4

endmodule

// File: rtl/crp_table.sv
module crp_table #(
    parameter int DEPTH = 256,
    parameter bit WRAP  = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld,
    input  logic [7:0] ld_val,
    input  logic       acc,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic [7:0] idx_rd,
    output logic [7:0] dat_rd
);
    localparam int AW = $clog2(DEPTH);
    localparam int IW = WRAP ? AW : AW + 1;

    logic [IW-1:0] idx;
    logic [7:0]    mem [DEPTH];
    logic          in_rng;

    generate
        if (WRAP) begin : g_wrap
            assign in_rng = 1'b1;
        end else begin : g_stop
            assign in_rng = (idx < IW'(DEPTH));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)                idx <= '0;
        else if (ld)               idx <= IW'(ld_val[AW-1:0]);
        else if (acc && in_rng)    idx <= idx + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (acc && wr && in_rng && !ld) mem[idx[AW-1:0]] <= wdata;
    end

    assign dat_rd = in_rng ? mem[idx[AW-1:0]] : 8'h00;
    assign idx_rd = 8'(idx);

    AST_TBL_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !ld && in_rng) |=> (idx == IW'($past(idx) + 1'b1)))
        else $error("table advance"); // R8
    AST_TBL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !ld && !in_rng) |=> $stable(idx))
        else $error("table stop"); // R9

endmodule

// File: rtl/crp_regs.sv
module crp_regs
    import crp_pkg::*;
#(
    parameter int NUM_COORD = 2,
    parameter int CRD_W     = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc,
    input  logic        live,
    input  logic        we,
    input  logic        dc,
    input  logic [7:0]  idx,
    input  logic [15:0] wdata,
    input  logic [7:0]  irq_set,
    input  logic [7:0]  gidx,
    input  logic [7:0]  gdat,
    input  logic [7:0]  fidx,
    input  logic [7:0]  fdat,
    output logic [15:0] rdata,
    output logic        disp_enable,
    output logic        disp_blank,
    output logic        invalidate,
    output logic        mem_push,
    output logic [15:0] mem_data,
    output logic        idx_err
);
    localparam int HI_W = CRD_W - 8;

    logic        wr;
    logic [6:0]  div_q;
    logic [7:0]  mode_q;
    logic [7:0]  irq_q;
    logic [NUM_COORD-1:0][CRD_W-1:0] crd_q;
    logic [15:0] rd_val;

    assign wr = live && we && dc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q      <= 7'd9;
            mode_q     <= 8'h00;
            irq_q      <= 8'h00;
            crd_q      <= '0;
            invalidate <= 1'b0;
            mem_push   <= 1'b0;
            mem_data   <= 16'h0000;
            idx_err    <= 1'b0;
        end else begin
            invalidate <= wr && (idx == IX_MODE) && (mode_q[1:0] != wdata[1:0]);
            mem_push   <= wr && (idx == IX_MEM);
            if (wr && idx == IX_MEM) mem_data <= wdata;
            if (wr && idx == IX_DIV)  div_q  <= {1'b0, wdata[5:0]} + 7'd1;
            if (wr && idx == IX_MODE) mode_q <= wdata[7:0] & MODE_WMASK;
            irq_q <= ((wr && idx == IX_IRQ) ? (irq_q & wdata[7:0]) : irq_q) | irq_set;
            for (int k = 0; k < NUM_COORD; k++) begin
                if (wr && idx == crd_lo(k)) crd_q[k][7:0]       <= wdata[7:0];
                if (wr && idx == crd_hi(k)) crd_q[k][CRD_W-1:8] <= wdata[HI_W-1:0];
            end
            if (live && dc && !is_known(idx, NUM_COORD)) idx_err <= 1'b1;
        end
    end

    always_comb begin
        rd_val = 16'h0000;
        case (idx)
            IX_REV:  rd_val = REV_VAL;
            IX_CFG:  rd_val = CFG_VAL;
            IX_DIV:  rd_val = {8'h00, 1'b1, 7'(div_q - 7'd1)};
            IX_FIDX: rd_val = {8'h00, fidx};
            IX_FDAT: rd_val = {8'h00, fdat};
            IX_MODE: rd_val = {8'h00, mode_q};
            IX_GIDX: rd_val = {8'h00, gidx};
            IX_GDAT: rd_val = {8'h00, gdat};
            IX_IRQ:  rd_val = {8'h00, irq_q};
            default: begin
                for (int k = 0; k < NUM_COORD; k++) begin
                    if (idx == crd_lo(k)) rd_val = {8'h00, crd_q[k][7:0]};
                    if (idx == crd_hi(k)) rd_val = 16'(crd_q[k][CRD_W-1:8]);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)          rdata <= 16'h0000;
        else if (acc && !we) rdata <= live ? rd_val : 16'h0000;
    end

    assign disp_enable = mode_q[0];
    assign disp_blank  = mode_q[1];

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        idx_err |=> idx_err)
        else $error("err sticky"); // R13
    AST_IRQ_AND: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && idx == IX_IRQ && irq_set == 8'h00) |=> ((irq_q & ~$past(wdata[7:0])) == 8'h00))
        else $error("irq and"); // R10
    AST_INV_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        invalidate |-> $past(wr && idx == IX_MODE))
        else $error("invalidate cause"); // R11
    AST_PUSH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        mem_push |-> (mem_data == $past(wdata)))
        else $error("push data"); // R12

endmodule

// File: rtl/crp_host_port.sv
module crp_host_port
    import crp_pkg::*;
#(
    parameter int SKIP_N      = 2,
    parameter int NUM_COORD   = 2,
    parameter int GAMMA_DEPTH = 256,
    parameter int FILT_DEPTH  = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_acc,
    input  logic        bus_we,
    input  logic        bus_dc,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic [7:0]  irq_set,
    output logic        disp_enable,
    output logic        disp_blank,
    output logic        invalidate,
    output logic        mem_push,
    output logic [15:0] mem_data,
    output logic        idx_err
);
    logic [7:0] cur_idx;
    logic       live;
    logic [7:0] gidx, gdat, fidx, fdat;
    logic       port_acc;
    logic       wr;

    assign wr       = live && bus_we && bus_dc;
    assign port_acc = live && (bus_dc || !bus_we);

    crp_seq #(.SKIP_N(SKIP_N)) u_seq (
        .clk(clk), .rst_n(rst_n), .acc(bus_acc), .we(bus_we), .dc(bus_dc),
        .wcmd(bus_wdata[7:0]), .cur_idx(cur_idx), .live(live)
    );

    crp_table #(.DEPTH(GAMMA_DEPTH), .WRAP(1'b1)) u_gamma (
        .clk(clk), .rst_n(rst_n),
        .ld(wr && cur_idx == IX_GIDX), .ld_val(bus_wdata[7:0]),
        .acc(port_acc && cur_idx == IX_GDAT), .wr(bus_we),
        .wdata(bus_wdata[7:0]), .idx_rd(gidx), .dat_rd(gdat)
    );

    crp_table #(.DEPTH(FILT_DEPTH), .WRAP(1'b0)) u_filt (
        .clk(clk), .rst_n(rst_n),
        .ld(wr && cur_idx == IX_FIDX), .ld_val(bus_wdata[7:0]),
        .acc(port_acc && cur_idx == IX_FDAT), .wr(bus_we),
        .wdata(bus_wdata[7:0]), .idx_rd(fidx), .dat_rd(fdat)
    );

    crp_regs #(.NUM_COORD(NUM_COORD)) u_regs (
        .clk(clk), .rst_n(rst_n), .acc(bus_acc), .live(live), .we(bus_we),
        .dc(bus_dc), .idx(cur_idx), .wdata(bus_wdata), .irq_set(irq_set),
        .gidx(gidx), .gdat(gdat), .fidx(fidx), .fdat(fdat),
        .rdata(bus_rdata), .disp_enable(disp_enable), .disp_blank(disp_blank),
        .invalidate(invalidate), .mem_push(mem_push), .mem_data(mem_data),
        .idx_err(idx_err)
    );

endmodule

// File: tb/crp_host_port_bench.sv
`timescale 1ns/1ps
module crp_host_port_bench;
    localparam int SKIP = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_acc = 1'b0, bus_we = 1'b0, bus_dc = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic [7:0]  irq_set = 8'h0;
    logic        disp_enable, disp_blank, invalidate, mem_push, idx_err;
    logic [15:0] mem_data;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // bench model
    int         m_skip = SKIP;
    logic [7:0] m_idx = 0, m_mode = 0, m_irq = 0, m_gidx = 0;
    int         m_div = 9, m_fidx = 0;
    logic [9:0] m_crd [2] = '{10'h0, 10'h0};
    logic [7:0] m_gtab [256];
    logic [7:0] m_ftab [32];
    bit         m_err = 0;

    always #5 clk = ~clk;

    crp_host_port #(.SKIP_N(SKIP)) u_crp_host_port (
        .clk(clk), .rst_n(rst_n), .bus_acc(bus_acc), .bus_we(bus_we),
        .bus_dc(bus_dc), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_set(irq_set), .disp_enable(disp_enable), .disp_blank(disp_blank),
        .invalidate(invalidate), .mem_push(mem_push), .mem_data(mem_data),
        .idx_err(idx_err)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic bit known(input logic [7:0] ix);
        case (ix)
            8'h00, 8'h02, 8'h04, 8'h58, 8'h5A, 8'h68, 8'h6C, 8'h6E,
            8'h70, 8'h72, 8'h90, 8'hB6, 8'hB8, 8'hF6: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic pulse_bus(input bit we, input bit dc, input logic [15:0] v);
        bus_acc = 1'b1; bus_we = we; bus_dc = dc; bus_wdata = v;
        @(negedge clk);
        bus_acc = 1'b0; irq_set = 8'h00;
    endtask

    task automatic op_cmd(input logic [7:0] v);
        if (m_skip > 0) m_skip--; else m_idx = v;
        pulse_bus(1'b1, 1'b0, {8'h00, v});
        chk("R4 no pulse on command", {14'h0, invalidate, mem_push}, 16'h0);
    endtask

    task automatic op_wr(input logic [15:0] v, input string req);
        bit e_inv = 0, e_push = 0;
        if (m_skip > 0) m_skip--;
        else begin
            case (m_idx)
                8'h04: m_div = int'(v[5:0]) + 1;
                8'h58: m_fidx = int'(v[4:0]);
                8'h5A: if (m_fidx < 32) begin m_ftab[m_fidx] = v[7:0]; m_fidx++; end
                8'h68: begin e_inv = ((m_mode[1:0] ^ v[1:0]) != 0); m_mode = v[7:0] & 8'hB7; end
                8'h6C: m_crd[0][7:0] = v[7:0];
                8'h6E: m_crd[0][9:8] = v[1:0];
                8'h70: m_crd[1][7:0] = v[7:0];
                8'h72: m_crd[1][9:8] = v[1:0];
                8'h90: e_push = 1;
                8'hB6: m_gidx = v[7:0];
                8'hB8: begin m_gtab[m_gidx] = v[7:0]; m_gidx++; end
                8'hF6: m_irq = (m_irq & v[7:0]) | irq_set;
                8'h00, 8'h02: ;
                default: m_err = 1;
            endcase
            if (m_idx != 8'h90 && m_idx != 8'h5A && m_idx != 8'hB8) m_idx += 8'd2;
        end
        pulse_bus(1'b1, 1'b1, v);
        chk({req, " R11 invalidate"}, {15'h0, invalidate}, {15'h0, e_inv});
        chk({req, " R12 mem_push"}, {15'h0, mem_push}, {15'h0, e_push});
        if (e_push) chk("R12 mem_data", mem_data, v);
        chk("R11 enable/blank", {14'h0, disp_blank, disp_enable}, {14'h0, m_mode[1:0]});
        chk("R13 idx_err", {15'h0, idx_err}, {15'h0, m_err});
    endtask

    task automatic op_rd(input bit dc, input string req);
        logic [15:0] e = 16'h0;
        if (m_skip > 0) m_skip--;
        else begin
            case (m_idx)
                8'h00: e = 16'h00A5;
                8'h02: e = 16'h0083;
                8'h04: e = 16'h0080 | 16'(m_div - 1);
                8'h58: e = 16'(m_fidx);
                8'h5A: if (m_fidx < 32) begin e = {8'h0, m_ftab[m_fidx]}; m_fidx++; end
                8'h68: e = {8'h0, m_mode};
                8'h6C: e = {8'h0, m_crd[0][7:0]};
                8'h6E: e = {14'h0, m_crd[0][9:8]};
                8'h70: e = {8'h0, m_crd[1][7:0]};
                8'h72: e = {14'h0, m_crd[1][9:8]};
                8'hB6: e = {8'h0, m_gidx};
                8'hB8: begin e = {8'h0, m_gtab[m_gidx]}; m_gidx++; end
                8'hF6: e = {8'h0, m_irq};
                default: e = 16'h0;
            endcase
            if (dc && !known(m_idx)) m_err = 1;
            if (dc) m_idx += 8'd1;
        end
        pulse_bus(1'b0, dc, 16'h0);
        chk(req, bus_rdata, e);
        chk("R13 idx_err", {15'h0, idx_err}, {15'h0, m_err});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] pick [14] = '{8'h00, 8'h02, 8'h04, 8'h58, 8'h5A, 8'h68, 8'h6C,
                                  8'h6E, 8'h70, 8'h72, 8'h90, 8'hB6, 8'hB8, 8'hF6};
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("reset rdata", bus_rdata, 16'h0);
        chk("reset outputs R11 R12 R13",
            {12'h0, disp_enable, disp_blank, mem_push, idx_err}, 16'h0);

        // R4: two swallowed accesses
        op_cmd(8'h04);
        op_rd(1'b1, "R4 swallowed read");
        op_rd(1'b1, "R4 R5 index untouched, reads rev");   // idx 0 -> 1
        op_rd(1'b1, "R13 unknown reads zero");              // idx 1, sets err

        // R5 / R3 / R2
        op_cmd(8'h00);
        op_wr(16'hFFFF, "R5 const write");                  // idx -> 2
        op_rd(1'b0, "R5 R2 cfg after advance");
        op_rd(1'b0, "R3 no advance with dc low");

        // R6 divider
        op_cmd(8'h04);
        op_rd(1'b0, "R6 reset divider");
        op_wr(16'hFFC5, "R6 write");
        op_cmd(8'h04); op_rd(1'b0, "R6 divider low bits");
        op_wr(16'h003F, "R6 write max");
        op_cmd(8'h04); op_rd(1'b0, "R6 divider max");

        // R7 coordinates
        op_cmd(8'h6C);
        op_wr(16'h12AB, "R7 low");
        op_wr(16'h0003, "R7 high");
        op_wr(16'h0155, "R7 y low");
        op_cmd(8'h6C); op_wr(16'h0055, "R7 low again");
        op_cmd(8'h6E); op_rd(1'b0, "R7 high kept");
        op_cmd(8'h6C); op_rd(1'b0, "R7 low read");
        op_cmd(8'h70); op_rd(1'b0, "R7 y low read");

        // R11 mode
        op_cmd(8'h68);
        op_wr(16'h00FF, "R11 set");
        op_cmd(8'h68);
        op_wr(16'h00B3, "R11 same low bits");
        op_cmd(8'h68); op_rd(1'b0, "R11 mask");

        // R12 memory port
        op_cmd(8'h90);
        op_wr(16'h1234, "R12 first");
        op_wr(16'hBEEF, "R12 second R2");
        op_rd(1'b0, "R12 read zero");

        // R8 gamma fill and wrap
        op_cmd(8'hB6); op_wr(16'h0000, "R8 index");
        op_cmd(8'hB8);
        for (int i = 0; i < 256; i++) op_wr(16'((i * 37 + 5) & 8'hFF), "R8 fill");
        op_cmd(8'hB6); op_rd(1'b0, "R8 wrap to zero");
        op_wr(16'h00FE, "R8 index FE");
        op_cmd(8'hB8);
        op_rd(1'b0, "R8 entry FE");
        op_rd(1'b0, "R8 entry FF");
        op_rd(1'b0, "R8 entry 00 after wrap");

        // R9 filter fill and saturation
        op_cmd(8'h58); op_wr(16'h0000, "R9 index");
        for (int i = 0; i < 32; i++) op_wr(16'(i * 11 + 3), "R9 fill");
        op_wr(16'h00EE, "R9 dropped");
        op_cmd(8'h58); op_rd(1'b0, "R9 index stops at 32");
        op_wr(16'h003E, "R9 index mask");
        op_cmd(8'h5A);
        op_rd(1'b0, "R9 entry 1E");
        op_rd(1'b0, "R9 entry 1F");
        op_rd(1'b0, "R9 past end reads zero");

        // R10 interrupt status
        irq_set = 8'hF0; m_irq |= 8'hF0;
        @(negedge clk); irq_set = 8'h00;
        op_cmd(8'hF6);
        op_wr(16'h003C, "R10 and clear");
        op_cmd(8'hF6); op_rd(1'b0, "R10 read");
        irq_set = 8'h01;
        op_wr(16'h0000, "R10 set wins");
        op_cmd(8'hF6); op_rd(1'b0, "R10 set over clear");

        // constrained random
        for (int n = 0; n < 600; n++) begin
            int r;
            r = int'($urandom % 8);
            if (r < 2)      op_cmd(pick[$urandom % 14]);
            else if (r < 5) op_wr(16'($urandom), "R2 random write");
            else if (r < 7) op_rd(1'b1, "R3 random read");
            else            op_rd(1'b0, "R3 random read dc low");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule